// File: doc/BRIEF.md
# Mixed-Decay PWM Chopper Controller

This block runs the fixed-frequency current chopper for one motor winding. A chopping oscillator supplies a tick on each of its rising edges, and four oscillator cycles make one chopping period. Every period opens with a short charge pulse that lets the current-sense comparator be read. If the current was still above the set-point when the period began, the block goes straight to decay after that pulse. If it was not, the block keeps charging until the comparator trips.

Once charging ends, the winding decays in slow mode. At the mixed-decay point chosen by a 2-bit setting, it switches to fast mode. The fast share runs from none to the whole period. A step-clock event restarts the period at the next oscillator tick, so a new current target takes effect within one oscillator cycle. A disable or overtemperature input turns the bridge off and holds the period at its start.

The comparator and the reference generation are outside this block. The output is a 2-bit bridge mode request that the gate-drive logic decodes.

Top module: `mdc_chopper`

## Requirements
- R1: After reset, and with no oscillator tick seen yet, `bridge_mode` is off (00).
- R2: `bridge_mode` encodes off=00, charge=01, slow decay=10, fast decay=11. A period restarts on the fourth tick after it began, and the cycle after any restart shows charge.
- R3: Each period begins with a sensing charge pulse of SENSE_LEN clocks. The comparator is ignored for the first BLANK_LEN clocks of that pulse.
- R4: After blanking within the sensing pulse, or at any time during full charge, `cur_hi`=1 ends charging. The next cycle shows decay.
- R5: The block samples `cur_hi` at the restarting tick. If it was 1, the block enters decay after the sensing pulse. If it was 0, the block keeps charging until the comparator trips.
- R6: The phase counts ticks 0..3 within the period. Decay is fast when phase >= 4-N, where `decay_sel` 00 gives N=0, 01 gives N=1, 10 gives N=2 and 11 gives N=4; otherwise decay is slow. So 11 means fast decay throughout, with no slow step.
- R7: A `step_evt` pulse restarts the period at the next tick: phase 0 and a new sensing pulse. A step that arrives in the same cycle as a tick restarts at that tick.
- R8: While `drv_off` or `ovt` is 1, `bridge_mode` is 00 in that same cycle. The phase is held at 0 and a pending step is dropped. After release, the output stays off until the next tick, which starts a period.
- R9: Once decay is entered, charge does not return until the period restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-clock pulse on each chopping oscillator rising edge |
| cur_hi | input | 1 | Comparator: winding current at or above set-point |
| decay_sel | input | 2 | Fast-decay share of the period |
| step_evt | input | 1 | One-clock pulse on a step-clock event |
| drv_off | input | 1 | Bridge disable |
| ovt | input | 1 | Overtemperature shutdown |
| bridge_mode | output | 2 | Requested bridge mode |

## Verification
The off-forcing from `drv_off` and `ovt` is combinational, so it is due in the same cycle as the input. Every other result is registered one edge after the tick, comparator level or step pulse that causes it. A restart on a tick shows charge in the following cycle. A comparator trip past blanking shows decay one cycle later. The slow-to-fast switch follows the phase tick by one cycle.

The bench drives inputs just after the falling edge and compares `bridge_mode` with its behavioural model 2 ns later. That model advances on the rising edge, so every expected value already includes the single register stage.

// File: rtl/mdc_chopper.sv
module mdc_chopper #(
  parameter int SENSE_LEN = 4,
  parameter int BLANK_LEN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       cur_hi,
  input  logic [1:0] decay_sel,
  input  logic       step_evt,
  input  logic       drv_off,
  input  logic       ovt,
  output logic [1:0] bridge_mode
);
  localparam int CW = (SENSE_LEN > 1) ? $clog2(SENSE_LEN) : 1;
  localparam logic [CW-1:0] SENSE_LAST = CW'(SENSE_LEN - 1);
  localparam logic [CW:0]   BLANK_END  = (CW+1)'(BLANK_LEN);

  localparam logic [1:0] ST_IDLE  = 2'd0;
  localparam logic [1:0] ST_SENSE = 2'd1;
  localparam logic [1:0] ST_CHRG  = 2'd2;
  localparam logic [1:0] ST_DCY   = 2'd3;

  logic [1:0]    st;
  logic [1:0]    ph;
  logic [CW-1:0] cnt;
  logic          skip;
  logic          pend;
  logic          off;
  logic          restart;
  logic [2:0]    nfast;
  logic          fast_zone;

  assign off     = drv_off | ovt;
  assign restart = osc_tick & ((st == ST_IDLE) | pend | step_evt | (ph == 2'd3));

  always_comb begin
    case (decay_sel)
      2'b00:   nfast = 3'd0;
      2'b01:   nfast = 3'd1;
      2'b10:   nfast = 3'd2;
      default: nfast = 3'd4;
    endcase
  end

  assign fast_zone = ({1'b0, ph} + nfast) >= 3'd4;

  always_ff @(posedge clk) begin
    if (!rst_n || off) begin
      st   <= ST_IDLE;
      ph   <= 2'd0;
      cnt  <= '0;
      skip <= 1'b0;
      pend <= 1'b0;
    end else if (restart) begin
      st   <= ST_SENSE;
      ph   <= 2'd0;
      cnt  <= '0;
      skip <= cur_hi;
      pend <= 1'b0;
    end else begin
      if (step_evt) pend <= 1'b1;
      if (osc_tick) ph <= ph + 2'd1;
      case (st)
        ST_SENSE: begin
          if (({1'b0, cnt} >= BLANK_END) && cur_hi) st <= ST_DCY;
          else if (cnt == SENSE_LAST)                st <= skip ? ST_DCY : ST_CHRG;
          else                                       cnt <= cnt + 1'b1;
        end
        ST_CHRG: if (cur_hi) st <= ST_DCY;
        default: ;
      endcase
    end
  end

  always_comb begin
    if (off) bridge_mode = 2'b00;
    else begin
      case (st)
        ST_IDLE:  bridge_mode = 2'b00;
        ST_SENSE,
        ST_CHRG:  bridge_mode = 2'b01;
        default:  bridge_mode = fast_zone ? 2'b11 : 2'b10;
      endcase
    end
  end
endmodule

module mdc_chopper_chk #(
  parameter int SENSE_LEN = 4,
  parameter int BLANK_LEN = 2,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          osc_tick,
  input logic [1:0]    decay_sel,
  input logic          drv_off,
  input logic          ovt,
  input logic [1:0]    bridge_mode,
  input logic [1:0]    st,
  input logic [1:0]    ph,
  input logic [CW-1:0] cnt
);
  logic off_any;
  assign off_any = drv_off | ovt;

  AST_OFF_NEXT: assert property (@(posedge clk) disable iff (!rst_n) off_any |=> bridge_mode == 2'b00); // R8
  AST_PH_HELD: assert property (@(posedge clk) disable iff (!rst_n) off_any |=> ph == 2'd0); // R8
  AST_NO_FAST_NORMAL: assert property (@(posedge clk) disable iff (!rst_n) decay_sel == 2'b00 |-> bridge_mode != 2'b11); // R6
  AST_FAST_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (decay_sel == 2'b11 && bridge_mode[1]) |-> bridge_mode == 2'b11); // R6
  AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (st == 2'd1 && int'(cnt) < BLANK_LEN && !osc_tick && !off_any) |=> bridge_mode == 2'b01); // R3
  AST_DECAY_STAYS: assert property (@(posedge clk) disable iff (!rst_n) (bridge_mode[1] && !osc_tick) |=> bridge_mode != 2'b01); // R9
  AST_TICK_CHARGE: assert property (@(posedge clk) disable iff (!rst_n) (!off_any && osc_tick && (st == 2'd0 || ph == 2'd3)) |=> !bridge_mode[1]); // R2
endmodule

bind mdc_chopper mdc_chopper_chk #(.SENSE_LEN(SENSE_LEN), .BLANK_LEN(BLANK_LEN), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .decay_sel(decay_sel),
  .drv_off(drv_off), .ovt(ovt), .bridge_mode(bridge_mode),
  .st(st), .ph(ph), .cnt(cnt)
);

// File: tb/mdc_chopper_tb.sv
module mdc_chopper_tb_top;
  localparam int SL = 4;
  localparam int BL = 2;
  localparam int TDIV = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic osc_tick = 0, cur_hi = 0, step_evt = 0, drv_off = 0, ovt = 0;
  logic [1:0] decay_sel = 2'b00;
  logic [1:0] bridge_mode;

  int checks = 0, errors = 0, cyc = 0, tcnt = 0;
  bit step_req = 0;
  string cur_req = "R1";

  int m_kind = 0, m_ph = 0, m_age = 0;
  bit m_skip = 0, m_pend = 0;

  always #10 clk = ~clk;

  mdc_chopper #(.SENSE_LEN(SL), .BLANK_LEN(BL)) dut_i (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .cur_hi(cur_hi),
    .decay_sel(decay_sel), .step_evt(step_evt), .drv_off(drv_off),
    .ovt(ovt), .bridge_mode(bridge_mode)
  );

  always @(posedge clk) begin
    if (!rst_n || drv_off || ovt) begin
      m_kind = 0; m_ph = 0; m_age = 0; m_skip = 0; m_pend = 0;
    end else if (osc_tick && (m_kind == 0 || m_pend || step_evt || m_ph == 3)) begin
      m_kind = 1; m_ph = 0; m_age = 0; m_skip = cur_hi; m_pend = 0;
    end else begin
      if (step_evt) m_pend = 1;
      if (osc_tick) m_ph = (m_ph + 1) % 4;
      if (m_kind == 1) begin
        if (m_age >= BL && cur_hi) m_kind = 3;
        else if (m_age == SL - 1) m_kind = m_skip ? 3 : 2;
        else m_age++;
      end else if (m_kind == 2 && cur_hi) m_kind = 3;
    end
  end

  function automatic int expect_mode();
    int share;
    if (drv_off || ovt || m_kind == 0) return 0;
    if (m_kind != 3) return 1;
    share = (decay_sel == 0) ? 0 : (decay_sel == 1) ? 1 : (decay_sel == 2) ? 2 : 4;
    return (m_ph + share >= 4) ? 3 : 2;
  endfunction

  function automatic string auto_tag(int e);
    if (e == 0) return (drv_off || ovt) ? "R8" : "R1";
    if (m_kind == 1) return "R3";
    if (m_kind == 2) return "R5";
    return "R6";
  endfunction

  task automatic tick1();
    int e;
    @(negedge clk);
    osc_tick = (tcnt == TDIV - 1);
    tcnt = (tcnt + 1) % TDIV;
    step_evt = step_req;
    step_req = 0;
    #2;
    e = expect_mode();
    checks++;
    if (int'(bridge_mode) != e) begin
      errors++;
      $display("FAIL %s/%s cycle %0d: bridge_mode actual %0d expected %0d",
               cur_req, auto_tag(e), cyc, bridge_mode, e);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick1();
  endtask

  task automatic wait_tick_slot();
    while (tcnt != TDIV - 1) tick1();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: off after reset before any tick
    cur_req = "R1";
    run(6);
    // R2: encoding and period restart every fourth tick
    cur_req = "R2";
    cur_hi = 0; run(20);
    cur_hi = 1; run(40);
    // R3: comparator toggles during blanking
    cur_req = "R3";
    for (int i = 0; i < 64; i++) begin cur_hi = (i % 3 == 0); tick1(); end
    // R4: trip during full charge
    cur_req = "R4";
    cur_hi = 0; wait_tick_slot(); run(12);
    cur_hi = 1; run(2);
    // R9: comparator falls back but decay holds
    cur_req = "R9";
    cur_hi = 0; run(10);
    // R5: current above set-point at boundary skips charge
    cur_req = "R5";
    cur_hi = 0; run(27);
    cur_hi = 1; run(40);
    // R6: all decay settings
    cur_req = "R6";
    for (int s = 0; s < 4; s++) begin
      decay_sel = 2'(s);
      cur_hi = 0; run(9);
      cur_hi = 1; run(39);
    end
    // R7: step events mid-period and on a tick
    cur_req = "R7";
    decay_sel = 2'b01;
    cur_hi = 1; run(11);
    step_req = 1; run(10);
    wait_tick_slot(); step_req = 1; run(20);
    cur_hi = 0; run(5); cur_hi = 1; step_req = 1; run(30);
    // R8: disable and overtemperature
    cur_req = "R8";
    run(3); drv_off = 1; run(10);
    drv_off = 0; run(20);
    step_req = 1; run(1); ovt = 1; run(9);
    ovt = 0; run(30);
    cur_hi = 0; wait_tick_slot(); drv_off = 1; run(1); drv_off = 0; run(25);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule